// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block walks a ring of transmit descriptors kept in a local descriptor store and turns each pending descriptor into a buffer read command for a downstream data mover. Software fills descriptor slots through a write port. It then announces new work by advancing a free-running producer counter. The engine owns a matching consumer counter. Whenever the two counters differ and the engine is enabled, it fetches the descriptor whose slot number is the low bits of the consumer counter. It decodes the descriptor and presents the command. It steps the consumer counter once the data mover accepts the command.

Each slot holds three 32-bit words: a length/status word, a low address word and a high address word. Neither counter is cleared to zero in normal operation. Software aligns the producer with whatever value the consumer holds, so the engine works from any starting value and wraps modulo 65536. Two enables gate the start of new work: a global DMA enable and a ring enable for the default queue. Dropping either one lets a command that is already presented finish, and starts nothing further.

Top module: `tx_ring_fetch`

## Requirements
- R1: While `rst_n` is low, both `prod_idx` and `cons_idx` take the parameter value `INDEX_INIT` (default 0xFFFD) and `cmd_valid` is low.
- R2: A descriptor write stores `desc_wdata` into slot `desc_slot`. Word select 0 is the length/status word, 1 is the low address word and 2 is the high address word. Word select 3 changes nothing. `cmd_addr` is {high word, low word} of the fetched slot.
- R3: When `cmd_valid` is low, both enables are high and `prod_idx` differs from `cons_idx`, `cmd_valid` rises on the next clock edge. The command then describes slot `cons_idx[7:0]`.
- R4: From the length/status word: `cmd_len` is bits 27:16 and `cmd_eop` is bit 14. `cmd_sop` is bit 13, `cmd_qtag` is bits 12:7 and `cmd_crc` is bit 6. All other bits are ignored.
- R5: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and every command field holds its value.
- R6: `cons_idx` increments by one, modulo 65536, on the edge where `cmd_valid` and `cmd_ready` are both high. It holds its value on every other edge.
- R7: When `prod_idx` equals `cons_idx` and no command is presented, the engine stays idle. A run that starts anywhere drains to equality, crossing both 65535→0 and slot 255→0.
- R8: With either enable low, no new command starts. A command already presented stays presented until it is accepted. `cons_idx` then advances once and stops there.
- R9: A producer write loads `prod_idx` on the next edge. It takes effect even on the same edge as a command acceptance.
- R10: A command's fields are captured when the fetch starts. Rewriting the fetched slot while the command waits does not change the presented fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_en | input | 1 | Global DMA enable |
| ring_en | input | 1 | Default-queue ring enable |
| desc_we | input | 1 | Descriptor word write strobe |
| desc_slot | input | 8 | Descriptor slot to write |
| desc_word | input | 2 | Word select within the slot |
| desc_wdata | input | 32 | Descriptor word data |
| prod_we | input | 1 | Producer counter write strobe |
| prod_wdata | input | 16 | New producer counter value |
| prod_idx | output | 16 | Producer counter |
| cons_idx | output | 16 | Consumer counter |
| cmd_valid | output | 1 | Buffer read command presented |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_addr | output | 64 | Buffer address |
| cmd_len | output | 12 | Buffer length in bytes |
| cmd_sop | output | 1 | Start of packet |
| cmd_eop | output | 1 | End of packet |
| cmd_crc | output | 1 | Append CRC request |
| cmd_qtag | output | 6 | Queue tag |

## Verification
Two functions can land on the same clock edge. One is a command acceptance, which steps the consumer, together with a producer write. The other is a descriptor rewrite aimed at the very slot whose command is waiting. The bench provokes the first by writing the producer on every cycle while the data mover is always ready. It provokes the second by stalling `cmd_ready` and rewriting the presented slot. A behavioural reference model, built from queues and integers, is compared with every output on every clock. It judges both cases: both counters must reflect both events, and the presented fields must keep their fetch-time values.

// File: rtl/txr_pkg.sv
// Package: shared types for the transmit ring fetch engine.
// Assumes a fixed descriptor layout of three 32-bit words per slot.
package txr_pkg;

    localparam int WORDS_PER_DESC = 3;
    localparam int LEN_W          = 12;
    localparam int QTAG_W         = 6;

    // Bit positions inside the length/status word
    localparam int LEN_LSB  = 16;
    localparam int EOP_BIT  = 14;
    localparam int SOP_BIT  = 13;
    localparam int QTAG_LSB = 7;
    localparam int CRC_BIT  = 6;

    // Word select codes
    localparam logic [1:0] WSEL_HEAD = 2'd0;
    localparam logic [1:0] WSEL_ALO  = 2'd1;
    localparam logic [1:0] WSEL_AHI  = 2'd2;

    // Decoded header fields kept per slot
    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic              eop;
        logic              sop;
        logic [QTAG_W-1:0] qtag;
        logic              crc;
    } desc_head_t;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_CMD  = 1'b1
    } fetch_st_e;

endpackage

// File: rtl/txr_desc_mem.sv
// Module: descriptor store, one bank per descriptor word.
// Bank 0 keeps only the decoded header fields; banks 1 and 2 keep the
// address words. Reads are synchronous: data appears the edge after re.
// Assumes a read and a write to the same slot in one cycle return old data.
module txr_desc_mem
    import txr_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SLOT_W-1:0] wslot,
    input  logic [1:0]        wword,
    input  logic [31:0]       wdata,
    input  logic              re,
    input  logic [SLOT_W-1:0] rslot,
    output desc_head_t        head,
    output logic [63:0]       addr
);

    localparam int DEPTH = 1 << SLOT_W;

    desc_head_t  wr_head;
    logic [31:0] q_word [WORDS_PER_DESC];

    // Extract the header fields from an incoming length/status word
    always_comb begin
        wr_head.len  = wdata[LEN_LSB +: LEN_W];
        wr_head.eop  = wdata[EOP_BIT];
        wr_head.sop  = wdata[SOP_BIT];
        wr_head.qtag = wdata[QTAG_LSB +: QTAG_W];
        wr_head.crc  = wdata[CRC_BIT];
    end

    for (genvar w = 0; w < WORDS_PER_DESC; w++) begin : g_bank
        if (w == 0) begin : g_head
            desc_head_t arr [DEPTH];
            desc_head_t q;

            // Store header fields for the selected slot
            always_ff @(posedge clk) begin
                if (we && wword == WSEL_HEAD)
                    arr[wslot] <= wr_head;
            end

            // Registered read of the header bank
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (re)
                    q <= arr[rslot];
            end

            assign head      = q;
            assign q_word[w] = '0;
        end else begin : g_addr
            logic [31:0] arr [DEPTH];
            logic [31:0] q;

            // Store an address word for the selected slot
            always_ff @(posedge clk) begin
                if (we && wword == 2'(w))
                    arr[wslot] <= wdata;
            end

            // Registered read of this address bank
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (re)
                    q <= arr[rslot];
            end

            assign q_word[w] = q;
        end
    end

    assign addr = {q_word[WSEL_AHI], q_word[WSEL_ALO]};

endmodule

// File: rtl/txr_index_regs.sv
// Module: producer and consumer counters.
// Producer is loaded by software; consumer steps by one on each accepted
// command. Both wrap naturally at their width and reset to INDEX_INIT.
module txr_index_regs #(
    parameter int              IDX_W      = 16,
    parameter logic [IDX_W-1:0] INDEX_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prod_we,
    input  logic [IDX_W-1:0] prod_wdata,
    input  logic             advance,
    output logic [IDX_W-1:0] prod,
    output logic [IDX_W-1:0] cons,
    output logic             pending
);

    // Software-loaded producer counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            prod <= INDEX_INIT;
        else if (prod_we)
            prod <= prod_wdata;
    end

    // Hardware consumer counter, one step per accepted command
    always_ff @(posedge clk) begin
        if (!rst_n)
            cons <= INDEX_INIT;
        else if (advance)
            cons <= cons + 1'b1;
    end

    // Work is outstanding whenever the counters differ
    always_comb pending = (prod != cons);

endmodule

// File: rtl/txr_fetch_ctrl.sv
// Module: two-state fetch sequencer.
// In IDLE it starts a descriptor read when enabled and work is pending;
// in CMD it presents the command until the data mover accepts it.
// Assumes enables are only sampled in IDLE, so a started fetch always completes.
module txr_fetch_ctrl
    import txr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pending,
    input  logic cmd_ready,
    output logic start,
    output logic cmd_valid,
    output logic accept
);

    fetch_st_e state;

    // Decode start and acceptance from the current state
    always_comb begin
        start     = (state == FS_IDLE) && enable && pending;
        cmd_valid = (state == FS_CMD);
        accept    = cmd_valid && cmd_ready;
    end

    // State transitions
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= FS_IDLE;
        else if (start)
            state <= FS_CMD;
        else if (accept)
            state <= FS_IDLE;
    end

endmodule

// File: rtl/tx_ring_fetch.sv
// Module: transmit descriptor ring fetch engine (top).
// Compares free-running producer/consumer counters and, when they differ
// and both enables are set, reads the slot addressed by the consumer's low
// bits and presents it as a buffer read command with a valid/ready handshake.
// Assumes software sets prod_idx equal to cons_idx before enabling.
module tx_ring_fetch
    import txr_pkg::*;
#(
    parameter int               IDX_W      = 16,
    parameter int               SLOT_W     = 8,
    parameter logic [IDX_W-1:0] INDEX_INIT = 16'hFFFD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_en,
    input  logic              ring_en,
    input  logic              desc_we,
    input  logic [SLOT_W-1:0] desc_slot,
    input  logic [1:0]        desc_word,
    input  logic [31:0]       desc_wdata,
    input  logic              prod_we,
    input  logic [IDX_W-1:0]  prod_wdata,
    output logic [IDX_W-1:0]  prod_idx,
    output logic [IDX_W-1:0]  cons_idx,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [63:0]       cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_sop,
    output logic              cmd_eop,
    output logic              cmd_crc,
    output logic [QTAG_W-1:0] cmd_qtag
);

    logic       enable;
    logic       pending;
    logic       start;
    logic       accept;
    desc_head_t head;

    // Both enables are required to begin new work
    always_comb enable = dma_en && ring_en;

    txr_index_regs #(
        .IDX_W      (IDX_W),
        .INDEX_INIT (INDEX_INIT)
    ) u_idx (
        .clk        (clk),
        .rst_n      (rst_n),
        .prod_we    (prod_we),
        .prod_wdata (prod_wdata),
        .advance    (accept),
        .prod       (prod_idx),
        .cons       (cons_idx),
        .pending    (pending)
    );

    txr_fetch_ctrl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .pending   (pending),
        .cmd_ready (cmd_ready),
        .start     (start),
        .cmd_valid (cmd_valid),
        .accept    (accept)
    );

    txr_desc_mem #(
        .SLOT_W (SLOT_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (desc_we),
        .wslot (desc_slot),
        .wword (desc_word),
        .wdata (desc_wdata),
        .re    (start),
        .rslot (cons_idx[SLOT_W-1:0]),
        .head  (head),
        .addr  (cmd_addr)
    );

    // Present the captured header fields as command fields
    always_comb begin
        cmd_len  = head.len;
        cmd_sop  = head.sop;
        cmd_eop  = head.eop;
        cmd_crc  = head.crc;
        cmd_qtag = head.qtag;
    end

endmodule

// File: rtl/txr_checker.sv
// Module: protocol and counter checks for tx_ring_fetch, bound to the top.
// Observes ports only.
module txr_checker
    import txr_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dma_en,
    input logic              ring_en,
    input logic [IDX_W-1:0]  prod_idx,
    input logic [IDX_W-1:0]  cons_idx,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [63:0]       cmd_addr,
    input logic [LEN_W-1:0]  cmd_len,
    input logic              cmd_sop,
    input logic              cmd_eop,
    input logic              cmd_crc,
    input logic [QTAG_W-1:0] cmd_qtag
);

    // Start of a fetch when enabled with work pending
    p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && dma_en && ring_en && prod_idx != cons_idx) |=> cmd_valid);

    // Stalled command holds still
    p_hold_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
            $stable(cmd_len) && $stable(cmd_sop) && $stable(cmd_eop) &&
            $stable(cmd_crc) && $stable(cmd_qtag)));

    // Consumer steps by one on acceptance
    p_cons_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (cons_idx == $past(cons_idx) + 1'b1));

    // Consumer holds without acceptance
    p_cons_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> (cons_idx == $past(cons_idx)));

    // Equal counters keep the engine idle
    p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && prod_idx == cons_idx) |=> !cmd_valid);

    // No new fetch while disabled
    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !(dma_en && ring_en)) |=> !cmd_valid);

endmodule

bind tx_ring_fetch txr_checker #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_en    (dma_en),
    .ring_en   (ring_en),
    .prod_idx  (prod_idx),
    .cons_idx  (cons_idx),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_sop   (cmd_sop),
    .cmd_eop   (cmd_eop),
    .cmd_crc   (cmd_crc),
    .cmd_qtag  (cmd_qtag)
);

// File: tb/sim_tx_ring_fetch.sv
// Bench: behavioural reference model compared against every output each clock.
module sim_tx_ring_fetch;

    localparam int INIT = 16'hFFFD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_en = 1'b0;
    logic        ring_en = 1'b0;
    logic        desc_we = 1'b0;
    logic [7:0]  desc_slot = '0;
    logic [1:0]  desc_word = '0;
    logic [31:0] desc_wdata = '0;
    logic        prod_we = 1'b0;
    logic [15:0] prod_wdata = '0;
    logic [15:0] prod_idx;
    logic [15:0] cons_idx;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [63:0] cmd_addr;
    logic [11:0] cmd_len;
    logic        cmd_sop;
    logic        cmd_eop;
    logic        cmd_crc;
    logic [5:0]  cmd_qtag;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int rdy_mode = 0;   // 0 low, 1 high, 2 random

    // Reference model state
    int          m_prod, m_cons;
    bit          m_valid;
    logic [31:0] m_mem [768];
    logic [31:0] m_w0, m_lo, m_hi;

    always #2.5 clk = ~clk;

    tx_ring_fetch u0 (.*);

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] head_word(input int s);
        head_word = (32'(s[3:0]) << 28) | (32'((s * 37 + 3) & 12'hFFF) << 16) |
                    (32'(s[1]) << 14) | (32'(s[0]) << 13) |
                    (32'((s >> 2) & 6'h3F) << 7) | (32'(s[2]) << 6) | 32'(s & 5'h1F);
    endfunction

    // Reference model update on every rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_prod = INIT; m_cons = INIT; m_valid = 0;
        end else begin
            bit hs, st;
            hs = m_valid && cmd_ready;
            st = !m_valid && dma_en && ring_en && (m_prod != m_cons);
            if (st) begin
                m_w0 = m_mem[(m_cons & 8'hFF) * 3 + 0];
                m_lo = m_mem[(m_cons & 8'hFF) * 3 + 1];
                m_hi = m_mem[(m_cons & 8'hFF) * 3 + 2];
                m_valid = 1;
            end
            if (desc_we && desc_word != 2'd3)
                m_mem[int'(desc_slot) * 3 + int'(desc_word)] = desc_wdata;
            if (hs) begin
                m_cons = (m_cons + 1) & 16'hFFFF;
                m_valid = 0;
            end
            if (prod_we) m_prod = int'(prod_wdata);
        end
    end

    // Compare on the falling edge, then drive the ready pattern
    always @(negedge clk) begin
        if (cycles > 0) begin
            check(cmd_valid == m_valid, "R3 cmd_valid", cmd_valid, m_valid);
            check(cons_idx == 16'(m_cons), "R6 cons_idx", cons_idx, m_cons);
            check(prod_idx == 16'(m_prod), "R9 prod_idx", prod_idx, m_prod);
            if (m_valid) begin
                check(cmd_addr == {m_hi, m_lo}, "R2 cmd_addr", cmd_addr, {m_hi, m_lo});
                check(cmd_len == m_w0[27:16], "R4 cmd_len", cmd_len, m_w0[27:16]);
                check({cmd_eop, cmd_sop, cmd_qtag, cmd_crc} ==
                      {m_w0[14], m_w0[13], m_w0[12:7], m_w0[6]},
                      "R4 flags", {cmd_eop, cmd_sop, cmd_qtag, cmd_crc},
                      {m_w0[14], m_w0[13], m_w0[12:7], m_w0[6]});
            end
        end
        cmd_ready <= (rdy_mode == 1) || (rdy_mode == 2 && ($urandom % 2 == 0));
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic wr_desc(input int s, input int w, input logic [31:0] d);
        @(negedge clk);
        desc_we = 1; desc_slot = 8'(s); desc_word = 2'(w); desc_wdata = d;
        @(negedge clk);
        desc_we = 0;
    endtask

    task automatic wr_prod(input int v);
        @(negedge clk);
        prod_we = 1; prod_wdata = 16'(v);
        @(negedge clk);
        prod_we = 0;
    endtask

    task automatic drain;
        while (!(m_prod == m_cons && !m_valid)) @(negedge clk);
        repeat (3) @(negedge clk);
        check(cons_idx == prod_idx && !cmd_valid, "R7 drained idle", cons_idx, prod_idx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(prod_idx == 16'(INIT), "R1 prod reset", prod_idx, INIT);
        check(cons_idx == 16'(INIT), "R1 cons reset", cons_idx, INIT);
        check(cmd_valid == 1'b0, "R1 valid reset", cmd_valid, 0);
        rst_n = 1;

        // Fill every slot; word 3 writes must be ignored (R2)
        for (int s = 0; s < 256; s++) begin
            wr_desc(s, 0, head_word(s));
            wr_desc(s, 1, 32'hA5A5_0000 ^ (32'(s) << 8) ^ 32'(s));
            wr_desc(s, 2, 32'(s) ^ 32'h0000_0055);
            if (s % 16 == 0) wr_desc(s, 3, 32'hDEAD_BEEF);
        end

        // Run across 65535->0 and slot 255->0 with ready high (R7)
        dma_en = 1; ring_en = 1; rdy_mode = 1;
        wr_prod(m_prod + 5);
        drain();
        check(cons_idx == 16'h0002, "R7 wrap", cons_idx, 16'h0002);

        // Random backpressure (R5)
        rdy_mode = 2;
        wr_prod(m_prod + 40);
        drain();

        // Disable while a command is stalled (R8)
        rdy_mode = 0;
        begin
            int c0;
            c0 = m_cons;
            wr_prod(m_prod + 3);
            while (!m_valid) @(negedge clk);
            dma_en = 0;
            repeat (4) @(negedge clk);
            check(cmd_valid == 1'b1, "R8 in-flight held", cmd_valid, 1);
            rdy_mode = 1;
            repeat (6) @(negedge clk);
            check(cons_idx == 16'(c0 + 1), "R8 one step", cons_idx, c0 + 1);
            check(cmd_valid == 1'b0, "R8 stopped", cmd_valid, 0);
        end
        ring_en = 0; dma_en = 1;
        repeat (4) @(negedge clk);
        check(cmd_valid == 1'b0, "R8 ring disabled", cmd_valid, 0);
        ring_en = 1;
        drain();

        // Rewrite the presented slot while stalled (R10)
        rdy_mode = 0;
        wr_prod(m_prod + 1);
        while (!m_valid) @(negedge clk);
        begin
            logic [11:0] l0;
            l0 = cmd_len;
            wr_desc(m_cons & 8'hFF, 0, 32'h0ABC_7FC0);
            repeat (2) @(negedge clk);
            check(cmd_len == l0, "R10 captured len", cmd_len, l0);
        end
        rdy_mode = 1;
        drain();

        // Producer writes coinciding with acceptances (R9)
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            prod_we = 1; prod_wdata = 16'(m_prod + 1);
        end
        @(negedge clk);
        prod_we = 0;
        drain();

        // Longer random run
        rdy_mode = 2;
        wr_prod(m_prod + 300);
        drain();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule